// File: doc/BRIEF.md
# Flash Completion Poll Controller

This block sits on the host side of a flash memory. It waits for an embedded program or erase to finish by reading a status word again and again and watching one flag bit (bit 7 by default). A program is still running while that bit reads as the inverse of the bit 7 that was written. An erase is still running while the bit reads 0. Once the bit shows its completed value, the block issues one more read. Only the word from that extra read is returned, because the flag can settle before the rest of the word does.

A caller pulses `startReq` with the operation type, the expected flag value and the address to poll. It raises `cmdDone` once the full command sequence has been written to the flash: after the sixth write pulse for a chip erase, or after the last sector write pulse for a sector erase. Reads go out on a request/acknowledge port. The loop ends in one of two ways. It gives a single-cycle `donePulse` together with the confirmed word. Or it gives a `timeoutErr` pulse after a programmable number of polls that did not show completion. For an erase, the caller also says whether the poll address lies inside a sector being erased and outside any protected sector. When it does not, the result is marked unreliable.

Top module: `statusPoller`

## Requirements
- R1: During and just after reset, `rdReq`, `busy`, `donePulse` and `timeoutErr` are all 0.
- R2: After an accepted start, no read is requested until `cmdDone` has been seen high. The first request rises in the cycle after that.
- R3: For a program (`opIsErase`=0), a poll read counts as complete when data bit 7 equals `expFlag`. For an erase (`opIsErase`=1), it counts as complete when data bit 7 is 1. `expFlag` is ignored for an erase.
- R4: A completed poll read never ends the sequence by itself. Exactly one further read follows it, so a run whose first n polls show busy makes n+2 reads in total.
- R5: `doneData` carries the full word returned by the confirming read, and it is valid in the cycle of `donePulse`.
- R6: `donePulse` and `timeoutErr` are each high for exactly one cycle per sequence, in the cycle after the final acknowledge.
- R7: When `maxPolls` consecutive poll reads all show busy, the sequence ends with `timeoutErr` and no `donePulse`, after exactly `maxPolls` reads.
- R8: `unreliable` is set at the end of a sequence if it was an erase and `addrOk` was 0 at the start. Otherwise it is 0. It holds until the next accepted start.
- R9: A `startReq` while `busy` is 1 is ignored. The address, the operation type and the flag target of the running sequence stay unchanged.
- R10: `donePulse` and `timeoutErr` are never high together.
- R11: Once `rdReq` is raised, it stays high until a cycle in which `rdAck` is 1. A read transfers in each cycle where both are 1.
- R12: A `maxPolls` value of 0 behaves like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start pulse, accepted only while idle |
| opIsErase | input | 1 | 1 = erase, 0 = program |
| expFlag | input | 1 | Bit 7 of the programmed data |
| pollAddr | input | AW | Address to poll |
| maxPolls | input | CW | Poll limit before timeout |
| addrOk | input | 1 | Poll address is in an erasing, unprotected sector |
| cmdDone | input | 1 | Command sequence has been fully written |
| rdReq | output | 1 | Read request |
| rdAddr | output | AW | Read address |
| rdAck | input | 1 | Read acknowledge; `rdData` valid |
| rdData | input | DW | Read data |
| busy | output | 1 | A sequence is in progress |
| donePulse | output | 1 | Completion confirmed |
| doneData | output | DW | Word from the confirming read |
| timeoutErr | output | 1 | Poll limit reached |
| unreliable | output | 1 | Erase polled at an unsuitable address |

## Verification
The assertions assume that the memory side never raises `rdAck` unless `rdReq` is high, and that `cmdDone` comes only after a start. The bench's memory model acknowledges only at falling edges where it sees `rdReq` high, and it inserts 0 to 2 wait cycles. The stimulus pulses `cmdDone` once per run, after a delay. It sweeps operation type, flag polarity, number of busy reads, poll limit (0 included) and latency. The bench predicts the read count, the ending and the word from that sweep. It also sends a stray start with other values while busy, to check that the running sequence keeps its address and result.

// File: rtl/pollPkg.sv
package pollPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAITCMD,
    ST_POLL,
    ST_CONFIRM
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch request fields at accepted start
    logic bumpCnt;   // one more busy poll seen
    logic takeWord;  // latch confirming read word
  } pollStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic flagMatch; // current read shows completion value
    logic lastTry;   // current poll is the last allowed
  } pollStatus_t;
endpackage

// File: rtl/pollDatapath.sv
module pollDatapath
  import pollPkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 20,
  parameter int CW = 8,
  parameter int FLAG_BIT = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  pollStrobe_t   strobe,
  input  logic          opIsErase,
  input  logic          expFlag,
  input  logic [AW-1:0] pollAddr,
  input  logic [CW-1:0] maxPolls,
  input  logic          addrOk,
  input  logic [DW-1:0] rdData,
  output pollStatus_t   status,
  output logic [AW-1:0] rdAddr,
  output logic [DW-1:0] doneData,
  output logic          unreliable
);
  logic          eraseQ;
  logic          wantQ;
  logic [CW-1:0] limitQ;
  logic [CW-1:0] cntQ;
  logic [CW:0]   triesNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseQ     <= 1'b0;
      wantQ      <= 1'b0;
      limitQ     <= '0;
      cntQ       <= '0;
      rdAddr     <= '0;
      doneData   <= '0;
      unreliable <= 1'b0;
    end else begin
      if (strobe.capture) begin
        eraseQ     <= opIsErase;
        wantQ      <= opIsErase ? 1'b1 : expFlag;
        limitQ     <= (maxPolls == '0) ? CW'(1) : maxPolls;
        cntQ       <= '0;
        rdAddr     <= pollAddr;
        unreliable <= opIsErase & ~addrOk;
      end else if (strobe.bumpCnt) begin
        cntQ <= cntQ + CW'(1);
      end
      if (strobe.takeWord) doneData <= rdData;
    end
  end

  assign triesNow         = {1'b0, cntQ} + (CW+1)'(1);
  assign status.lastTry   = triesNow >= {1'b0, limitQ};
  assign status.flagMatch = (rdData[FLAG_BIT] == wantQ);

  // R3: an erase always targets a 1 on the flag bit
  a_r3_erase_target: assert property (@(posedge clk) disable iff (!rstN)
    eraseQ |-> wantQ);
  // R12: limit never zero once a sequence is captured
  a_r12_limit_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capture) |-> (limitQ != '0));
endmodule

// File: rtl/pollControl.sv
module pollControl
  import pollPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        cmdDone,
  input  logic        rdAck,
  input  pollStatus_t status,
  output pollStrobe_t strobe,
  output logic        rdReq,
  output logic        busy,
  output logic        donePulse,
  output logic        timeoutErr
);
  pollState_t stateQ, stateD;
  logic doneD, errD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    doneD  = 1'b0;
    errD   = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (startReq) begin
        strobe.capture = 1'b1;
        stateD = ST_WAITCMD;
      end
      ST_WAITCMD: if (cmdDone) stateD = ST_POLL;
      ST_POLL: if (rdAck) begin
        if (status.flagMatch) begin
          stateD = ST_CONFIRM;
        end else if (status.lastTry) begin
          errD   = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strobe.bumpCnt = 1'b1;
        end
      end
      ST_CONFIRM: if (rdAck) begin
        strobe.takeWord = 1'b1;
        doneD  = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      donePulse  <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      stateQ     <= stateD;
      donePulse  <= doneD;
      timeoutErr <= errD;
    end
  end

  assign rdReq = (stateQ == ST_POLL) || (stateQ == ST_CONFIRM);
  assign busy  = (stateQ != ST_IDLE);

  // R2: first request only after command completion was seen
  a_r2_wait_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdReq) |-> $past(cmdDone));
  // R11: request held until acknowledged
  a_r11_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> rdReq);
  // R6: completion pulses last one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  a_r6_err_single: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr);
  // R10: never both endings at once
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && timeoutErr));
  // R7: a timeout follows an acknowledged read
  a_r7_err_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> $past(rdAck && rdReq));
endmodule

// File: rtl/statusPoller.sv
module statusPoller
  import pollPkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 20,
  parameter int CW = 8,
  parameter int FLAG_BIT = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          opIsErase,
  input  logic          expFlag,
  input  logic [AW-1:0] pollAddr,
  input  logic [CW-1:0] maxPolls,
  input  logic          addrOk,
  input  logic          cmdDone,
  output logic          rdReq,
  output logic [AW-1:0] rdAddr,
  input  logic          rdAck,
  input  logic [DW-1:0] rdData,
  output logic          busy,
  output logic          donePulse,
  output logic [DW-1:0] doneData,
  output logic          timeoutErr,
  output logic          unreliable
);
  pollStrobe_t strobe;
  pollStatus_t status;

  pollControl uCtl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmdDone(cmdDone),
    .rdAck(rdAck), .status(status), .strobe(strobe), .rdReq(rdReq),
    .busy(busy), .donePulse(donePulse), .timeoutErr(timeoutErr)
  );

  pollDatapath #(.DW(DW), .AW(AW), .CW(CW), .FLAG_BIT(FLAG_BIT)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opIsErase(opIsErase),
    .expFlag(expFlag), .pollAddr(pollAddr), .maxPolls(maxPolls),
    .addrOk(addrOk), .rdData(rdData), .status(status), .rdAddr(rdAddr),
    .doneData(doneData), .unreliable(unreliable)
  );

  // transfers seen in the current sequence, saturating at 2
  logic [1:0] xferCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xferCnt <= '0;
    else if (!busy) xferCnt <= '0;
    else if (rdReq && rdAck && xferCnt != 2'd2) xferCnt <= xferCnt + 2'd1;
  end

  // R4: completion needs at least a poll read plus the confirming read
  a_r4_two_reads: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (xferCnt == 2'd2));
  // R5: returned word is the one on the final acknowledge
  a_r5_word: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (doneData == $past(rdData)));
  // R9: address frozen while a sequence runs
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdAddr));
  // R1: nothing requested while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdReq);
endmodule

// File: tb/sim_statusPoller.sv
`timescale 1ns/1ps
module sim_statusPoller;
  localparam int DW = 32, AW = 20, CW = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic startReq = 0, opIsErase = 0, expFlag = 0, addrOk = 0, cmdDone = 0;
  logic [AW-1:0] pollAddr = '0;
  logic [CW-1:0] maxPolls = '0;
  logic rdReq, rdAck = 0, busy, donePulse, timeoutErr, unreliable;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] rdData = '0, doneData;

  int nChecks = 0, nFails = 0;
  int gBusyN = 0, gLat = 0, rdIdx = 0, waitCnt = 0;
  logic [DW-1:0] gFinal = '0;
  logic gTrue = 0, cmdGiven = 0, earlyRead = 0, addrBad = 0;
  logic [AW-1:0] gAddr = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  statusPoller #(.DW(DW), .AW(AW), .CW(CW)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opIsErase(opIsErase),
    .expFlag(expFlag), .pollAddr(pollAddr), .maxPolls(maxPolls),
    .addrOk(addrOk), .cmdDone(cmdDone), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdAck(rdAck), .rdData(rdData), .busy(busy), .donePulse(donePulse),
    .doneData(doneData), .timeoutErr(timeoutErr), .unreliable(unreliable)
  );

  function automatic logic [DW-1:0] wordAt(int i);
    logic [DW-1:0] w;
    if (i < gBusyN) begin w = gFinal ^ 32'h00A5_3C00; w[7] = ~gTrue; end
    else if (i == gBusyN) begin w = gFinal ^ 32'h5A00_0041; w[7] = gTrue; end
    else w = gFinal;
    return w;
  endfunction

  // memory model: acknowledges at falling edges after gLat wait cycles
  always @(negedge clk) begin
    if (rdReq) begin
      if (!cmdGiven) earlyRead = 1;
      if (rdAddr != gAddr) addrBad = 1;
      if (waitCnt < gLat) begin
        waitCnt = waitCnt + 1;
        rdAck = 0;
      end else begin
        waitCnt = 0;
        rdAck = 1;
        rdData = wordAt(rdIdx);
        rdIdx = rdIdx + 1;
      end
    end else begin
      rdAck = 0;
      waitCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runCase(input bit erase, input bit aOk, input int nBusy,
                         input int maxP, input int lat, input logic [DW-1:0] expD);
    int effMax, cyc, expReads;
    bit expDone, expUnrel;
    effMax   = (maxP == 0) ? 1 : maxP;
    expDone  = nBusy < effMax;
    expReads = expDone ? nBusy + 2 : effMax;
    expUnrel = erase && !aOk;
    @(negedge clk);
    gBusyN = nBusy; gLat = lat; rdIdx = 0; cmdGiven = 0; earlyRead = 0; addrBad = 0;
    gTrue  = erase ? 1'b1 : expD[7];
    gFinal = erase ? '1 : expD;
    gAddr  = AW'(expD ^ 32'h0001_2345);
    startReq = 1; opIsErase = erase; expFlag = expD[7]; addrOk = aOk;
    pollAddr = gAddr; maxPolls = CW'(maxP);
    @(negedge clk);
    startReq = 0;
    repeat (lat + 1) @(negedge clk);
    chk(!rdReq && busy, "R2", "request before cmdDone", rdReq, 0);
    cmdDone = 1; cmdGiven = 1;
    @(negedge clk);
    cmdDone = 0;
    // R9: stray start with other values while busy
    startReq = 1; pollAddr = ~gAddr; opIsErase = ~erase; expFlag = ~expD[7];
    addrOk = ~aOk; maxPolls = CW'(maxP + 9);
    @(negedge clk);
    startReq = 0; pollAddr = gAddr;
    cyc = 0;
    while (!donePulse && !timeoutErr && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 400) begin
      chk(0, "R6", "case watchdog", cyc, 0);
      return;
    end
    chk(!(donePulse && timeoutErr), "R10", "both endings", {donePulse, timeoutErr}, 0);
    if (maxP == 0)
      chk(timeoutErr == !expDone, "R12", "zero limit ending", timeoutErr, !expDone);
    chk(donePulse == expDone, expDone ? "R3" : "R7", "ending kind", donePulse, expDone);
    chk(rdIdx == expReads, expDone ? "R4" : "R7", "read count", rdIdx, expReads);
    if (expDone) chk(doneData == gFinal, "R5", "done word", doneData, gFinal);
    chk(unreliable == expUnrel, "R8", "unreliable flag", unreliable, expUnrel);
    chk(!addrBad, "R9", "address changed", addrBad, 0);
    chk(!earlyRead, "R2", "early read", earlyRead, 0);
    @(negedge clk);
    chk(!donePulse && !timeoutErr && !busy, "R6", "pulse width",
        {donePulse, timeoutErr, busy}, 0);
    chk(!rdReq, "R11", "request after end", rdReq, 0);
    chk(unreliable == expUnrel, "R8", "flag held", unreliable, expUnrel);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "R6", "global watchdog", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int lims[4] = '{0, 1, 3, 6};
    logic [DW-1:0] exps[2] = '{32'h1234_5680, 32'h89AB_CD4E};
    repeat (3) @(negedge clk);
    chk(!rdReq && !busy && !donePulse && !timeoutErr, "R1", "in reset",
        {rdReq, busy, donePulse, timeoutErr}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!rdReq && !busy && !donePulse && !timeoutErr, "R1", "after reset",
        {rdReq, busy, donePulse, timeoutErr}, 0);
    for (int e = 0; e < 2; e++)
      for (int x = 0; x < 2; x++)
        for (int b = 0; b < 5; b++)
          for (int m = 0; m < 4; m++)
            for (int l = 0; l < 3; l++)
              runCase(e[0], b[0], b, lims[m], l, exps[x]);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule